// File: doc/BRIEF.md
# Masked Configuration Header Store

This block holds a standard configuration header as byte-addressed storage of `SPACE_BYTES` bytes. A requester presents one access per cycle: a byte offset, a length of 1 to 4 bytes, a read/write flag and up to 32 bits of little-endian write data. Byte `k` of the data goes to, or comes from, address `offset+k`. One cycle after the request the block raises an acknowledge. For a read, the data arrives in that same cycle. If the access is malformed, an error flag pulses alongside the acknowledge.

Writes to the first 64 bytes go through a writable-bit mask that is fixed per byte. Bits that are not in the mask keep their value. The upper byte of the status word is write-one-to-clear. A full-word write of all ones in the address field of the expansion-ROM base register clears that register to zero, which reports that no ROM is present. Bytes at addresses 0x40 and above hold whatever was written. Reset loads a computed default image, then clears the three enable bits of the command word and the whole ROM base register.

Top module: `hdr_cfg_store`

## Requirements
- R1: After reset, byte i holds (29*i + 0x5B) mod 256, with two exceptions. Bits 2:0 of byte 0x04 read 0, and bytes 0x30 to 0x33 read 0.
- R2: Below 0x40, a write sets byte i to (old AND NOT m) OR (data AND m). The mask m is 0xFF at 0x04, 0x0C, 0x3C and 0x10 to 0x27. It is 0x07 at 0x05, 0x01 at 0x30, 0xF8 at 0x31, and 0xFF at 0x32 and 0x33. Every other byte below 0x40 has m = 0x00; byte 0x07 is covered by R3.
- R3: Byte 0x07 uses mask 0xF9 and is write-one-to-clear: it becomes old AND NOT (data AND 0xF9). A 0 written to a bit leaves that bit unchanged.
- R4: Bytes from 0x40 up to SPACE_BYTES-1 store the written byte unchanged.
- R5: Data lanes are little-endian. Bits 8k+7:8k map to offset+k for each k below the length. On a read, lanes at or above the length return zero.
- R6: The access is rejected when the length is 0, the length is greater than 4, or offset+length is greater than SPACE_BYTES. A rejected access raises the error flag together with the acknowledge, returns zero data and changes no byte.
- R7: A write at offset 0x30 with length 4 and data bits 31:11 all ones sets bytes 0x30 to 0x33 to zero. Every other write to those bytes follows R2.
- R8: The acknowledge is high exactly one cycle after a request cycle. Read data is valid in that cycle. A read accepted in the cycle after a write returns the written result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Starting byte offset |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_ack | output | 1 | Access completed |
| rsp_err | output | 1 | Access rejected (pulses with rsp_ack) |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions check several rules on every cycle:
- Read-only bits of each masked byte never change, except through the ROM clear.
- The write-one-to-clear byte never gains a set bit.
- A rejected access leaves the whole store unchanged and returns zero data.
- An error never appears without an acknowledge, and an acknowledge always follows a request.
- A qualifying ROM write always leaves that register at zero.

Only the bench scenarios can show the exact reset image, the per-byte mask values, the lane ordering, and the choice between the ROM clear and a normal masked write. They do this by sweeping every address with several patterns and comparing against a model built from the requirements.

// File: rtl/hdr_cfg_pkg.sv
package hdr_cfg_pkg;

  localparam int unsigned MASKED_END  = 64;
  localparam int unsigned W1C_BYTE    = 7;
  localparam int unsigned ROM_BASE    = 48;
  localparam int unsigned CMD_LO      = 4;
  localparam int unsigned LANES       = 4;

  // writable-bit mask per byte; everything past the masked region is free
  function automatic logic [7:0] wr_mask(int unsigned i);
    logic [7:0] m;
    m = 8'h00;
    if (i >= MASKED_END)                  m = 8'hFF;
    else if (i == 4 || i == 12 || i == 60) m = 8'hFF;
    else if (i == 5)                      m = 8'h07;
    else if (i == 7)                      m = 8'hF9;
    else if (i >= 16 && i < 40)           m = 8'hFF;
    else if (i == 48)                     m = 8'h01;
    else if (i == 49)                     m = 8'hF8;
    else if (i == 50 || i == 51)          m = 8'hFF;
    return m;
  endfunction

  function automatic logic [7:0] image_byte(int unsigned i);
    return 8'((i * 29 + 91) % 256);
  endfunction

  function automatic logic [7:0] reset_byte(int unsigned i);
    logic [7:0] v;
    v = image_byte(i);
    if (i == CMD_LO) v = v & 8'hF8;
    if (i >= ROM_BASE && i < ROM_BASE + 4) v = 8'h00;
    return v;
  endfunction

endpackage

// File: rtl/hdr_cfg_check.sv
module hdr_cfg_check #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LEN_W       = 3,
  parameter int unsigned SPACE_BYTES = 128
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] offset,
  input  logic [LEN_W-1:0]  len,
  input  logic [20:0]       rom_field,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic              rom_clr
);
  import hdr_cfg_pkg::*;

  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] end_pos;
  logic             len_ok;
  logic             range_ok;

  always_comb begin
    end_pos  = {1'b0, offset} + SUM_W'(len);
    len_ok   = (len != '0) && (len <= LEN_W'(LANES));
    range_ok = end_pos <= SUM_W'(SPACE_BYTES);
    acc_ok   = valid && len_ok && range_ok;
    acc_bad  = valid && !(len_ok && range_ok);
    rom_clr  = acc_ok && write && (offset == ADDR_W'(ROM_BASE)) &&
               (len == LEN_W'(LANES)) && (&rom_field);
  end

endmodule

// File: rtl/hdr_cfg_cell.sv
module hdr_cfg_cell #(
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] MASK    = 8'hFF,
  parameter bit         W1C     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       clr,
  output logic [7:0] q
);

  logic [7:0] q_nxt;
  logic       q_en;

  always_comb begin
    q_en  = wr_en || clr;
    q_nxt = q;
    if (clr)
      q_nxt = 8'h00;
    else if (wr_en) begin
      if (W1C) q_nxt = q & ~(wr_byte & MASK);
      else     q_nxt = (q & ~MASK) | (wr_byte & MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (q_en) q <= q_nxt;
  end

  generate
    if (MASK != 8'hFF) begin : g_ro_chk
      // R2
      ro_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & ~MASK) == ($past(q) & ~MASK)));
    end
    if (W1C) begin : g_w1c_chk
      // R3
      no_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & ~$past(q)) == 8'h00));
    end
  endgenerate

endmodule

// File: rtl/hdr_cfg_store.sv
module hdr_cfg_store #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LEN_W       = 3,
  parameter int unsigned SPACE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  import hdr_cfg_pkg::*;

  localparam int unsigned SUM_W  = ADDR_W + 1;
  localparam int unsigned IDX_W  = $clog2(SPACE_BYTES);
  localparam int unsigned DATA_W = 8 * LANES;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic acc_ok, acc_bad, rom_clr;

  hdr_cfg_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SPACE_BYTES(SPACE_BYTES)
  ) u_check (
    .valid    (req_valid),
    .write    (req_write),
    .offset   (req_offset),
    .len      (req_len),
    .rom_field(req_wdata[31:11]),
    .acc_ok   (acc_ok),
    .acc_bad  (acc_bad),
    .rom_clr  (rom_clr)
  );

  logic [7:0]               cell_q [SPACE_BYTES];
  logic [8*SPACE_BYTES-1:0] store_flat;
  logic                     wr_go;

  assign wr_go = acc_ok && req_write;

  for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_cell
    localparam bit IS_ROM = (i >= ROM_BASE) && (i < ROM_BASE + LANES);
    logic [SUM_W-1:0] rel;
    logic             hit;
    logic [7:0]       lane_byte;
    logic             cell_clr;

    always_comb begin
      rel       = SUM_W'(i) - {1'b0, req_offset};
      hit       = wr_go && (rel < SUM_W'(req_len));
      lane_byte = req_wdata[{rel[1:0], 3'b000} +: 8];
    end

    if (IS_ROM) begin : g_rom
      assign cell_clr = rom_clr;
    end else begin : g_plain
      assign cell_clr = 1'b0;
    end

    hdr_cfg_cell #(
      .RST_VAL(reset_byte(i)),
      .MASK   (wr_mask(i)),
      .W1C    (i == W1C_BYTE)
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .wr_en  (hit),
      .wr_byte(lane_byte),
      .clr    (cell_clr),
      .q      (cell_q[i])
    );

    assign store_flat[8*i +: 8] = cell_q[i];
  end

  // read path and response next-state
  logic              rd_go;
  logic [SUM_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rdata_nxt;
  logic              ack_nxt, err_nxt;

  always_comb begin
    rd_go     = acc_ok && !req_write;
    rdata_nxt = '0;
    rd_idx    = '0;
    for (int k = 0; k < LANES; k++) begin
      rd_idx = {1'b0, req_offset} + SUM_W'(k);
      if (rd_go && (LEN_W'(k) < req_len) && (rd_idx < SUM_W'(SPACE_BYTES)))
        rdata_nxt[8*k +: 8] = cell_q[rd_idx[IDX_W-1:0]];
    end
    ack_nxt = req_valid;
    err_nxt = acc_bad;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_ack   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= ack_nxt;
      rsp_err   <= err_nxt;
      rsp_rdata <= rdata_nxt;
    end
  end

  // R6
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> rsp_ack);
  // R6
  bad_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc_bad |=> $stable(store_flat));
  // R6
  bad_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> (rsp_rdata == '0));
  // R8
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_ack |-> $past(req_valid));
  // R7
  rom_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rom_clr |=> ({cell_q[ROM_BASE+3], cell_q[ROM_BASE+2],
                  cell_q[ROM_BASE+1], cell_q[ROM_BASE]} == 32'h0));

endmodule

// File: tb/hdr_cfg_store_test.sv
`timescale 1ns/1ps
module hdr_cfg_store_test;

  localparam int SPACE = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_offset;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_ack, rsp_err;
  logic [31:0] rsp_rdata;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] mdl [SPACE];
  logic [31:0] lfsr = 32'h1D872B41;

  always #10 clk = ~clk;

  hdr_cfg_store #(.ADDR_W(8), .LEN_W(3), .SPACE_BYTES(SPACE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  function automatic logic [7:0] exp_mask(int i);
    if (i >= 64) return 8'hFF;
    case (i)
      4, 12, 60, 50, 51: return 8'hFF;
      5:  return 8'h07;
      7:  return 8'hF9;
      48: return 8'h01;
      49: return 8'hF8;
      default: return (i >= 16 && i < 40) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_reset(int i);
    logic [7:0] v;
    v = 8'((29 * i + 91) % 256);
    if (i == 4) v = v & 8'hF8;
    if (i >= 48 && i < 52) v = 8'h00;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(int off, int len);
    return (len == 0) || (len > 4) || (off + len > SPACE);
  endfunction

  task automatic model_write(int off, int len, logic [31:0] d);
    if (is_bad(off, len)) return;
    if (off == 48 && len == 4 && (&d[31:11])) begin
      for (int k = 48; k < 52; k++) mdl[k] = 8'h00;
      return;
    end
    for (int k = 0; k < len; k++) begin
      logic [7:0] b, m;
      b = d[8*k +: 8];
      m = exp_mask(off + k);
      if (off + k == 7) mdl[off+k] = mdl[off+k] & ~(b & m);
      else              mdl[off+k] = (mdl[off+k] & ~m) | (b & m);
    end
  endtask

  function automatic logic [31:0] model_read(int off, int len);
    logic [31:0] r;
    r = '0;
    if (is_bad(off, len)) return r;
    for (int k = 0; k < len; k++) r[8*k +: 8] = mdl[off+k];
    return r;
  endfunction

  task automatic xact(input bit w, input int off, input int len,
                      input logic [31:0] d,
                      output logic ack, output logic err, output logic [31:0] rd);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = w;
    req_offset = 8'(off);
    req_len    = 3'(len);
    req_wdata  = d;
    @(negedge clk);
    req_valid  = 1'b0;
    ack = rsp_ack; err = rsp_err; rd = rsp_rdata;
  endtask

  task automatic do_write(string req, int off, int len, logic [31:0] d);
    logic a, e; logic [31:0] r;
    xact(1'b1, off, len, d, a, e, r);
    check({req, "/R8 ack"}, {31'b0, a}, 32'd1);
    model_write(off, len, d);
  endtask

  task automatic do_read(string req, int off, int len);
    logic a, e; logic [31:0] r;
    xact(1'b0, off, len, 32'h0, a, e, r);
    check({req, "/R8 ack"}, {31'b0, a}, 32'd1);
    check(req, r, model_read(off, len));
  endtask

  task automatic do_bad(bit w, int off, int len, logic [31:0] d);
    logic a, e; logic [31:0] r;
    xact(w, off, len, d, a, e, r);
    check("R6 ack", {31'b0, a}, 32'd1);
    check("R6 err", {31'b0, e}, 32'd1);
    check("R6 data", r, 32'h0);
  endtask

  task automatic verify_all(string req);
    for (int i = 0; i < SPACE; i++) do_read(req, i, 1);
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_offset = '0; req_len = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 ack idle", {31'b0, rsp_ack}, 32'd0);
    for (int i = 0; i < SPACE; i++) mdl[i] = exp_reset(i);
    verify_all("R1 reset image");

    // R3: explicit write-one-to-clear behaviour on byte 0x07 (reset 0x26)
    do_write("R3", 7, 1, 32'h00);
    do_read("R3 zero no effect", 7, 1);
    check("R3 value", {24'b0, mdl[7]}, 32'h26);
    do_write("R3", 7, 1, 32'h20);
    do_read("R3 clear bit5", 7, 1);
    check("R3 value", {24'b0, mdl[7]}, 32'h06);

    // R2 R4: per-byte sweep with several patterns
    foreach (mdl[i]) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : (p == 2) ? 8'hA5 : 8'h5A;
        if (i == 48) continue;
        do_write(i < 64 ? "R2" : "R4", i, 1, {24'h0, pat});
        do_read(i < 64 ? "R2 sweep" : "R4 sweep", i, 1);
      end
    end

    // R7: ROM clear versus masked writes
    do_write("R7", 48, 4, 32'h12345679);
    do_read("R7 masked", 48, 4);
    check("R7 masked value", model_read(48, 4), 32'h12345001);
    do_write("R7", 48, 4, 32'hFFFFF801);
    do_read("R7 cleared", 48, 4);
    check("R7 cleared value", model_read(48, 4), 32'h0);
    do_write("R7", 48, 2, 32'h0000F800);
    do_read("R7 short no clear", 48, 4);
    do_write("R7", 48, 4, 32'hFFFFF000);
    do_read("R7 bit11 clear no collapse", 48, 4);

    // R6: rejected accesses
    do_bad(1'b1, 126, 4, 32'hFFFFFFFF);
    do_bad(1'b1, 16, 0, 32'hFFFFFFFF);
    do_bad(1'b1, 16, 5, 32'hFFFFFFFF);
    do_bad(1'b0, 200, 1, 32'h0);
    do_bad(1'b0, 127, 2, 32'h0);
    verify_all("R6 no change");

    // R5 R8: multi-byte little-endian accesses, back-to-back write then read
    for (int n = 0; n < 600; n++) begin
      int off, len;
      lfsr = next_rand(lfsr);
      off = int'(lfsr[6:0]);
      len = 1 + int'(lfsr[9:8]);
      if (off + len > SPACE) off = SPACE - len;
      if (lfsr[12]) begin
        logic [31:0] d;
        lfsr = next_rand(lfsr);
        d = lfsr;
        do_write("R5", off, len, d);
        do_read("R5 lanes", off, len);
      end else begin
        do_read("R5 read", off, len);
      end
    end
    do_write("R5", 64, 4, 32'h44332211);
    do_read("R5 partial", 64, 2);
    check("R5 partial value", model_read(64, 2), 32'h00002211);
    verify_all("R5 final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule